// File: doc/BRIEF.md
# Chained-Link Response Receiver with Length-Prefixed Buffer

This block sits at the receiving end of a point-to-point serial chain. It takes in response messages one 10-bit word at a time. Each word carries two flag bits and one data byte. The block checks the byte that closes each message against a CRC it computes itself. It packs the data bytes two to a 16-bit word into a dual-port buffer. Once the message is complete, it writes a byte count into the word where that message began.

Messages are appended back to back, so a host can let several responses pile up and then read them all in one pass. To size that pass, the host reads the write pointer and subtracts two. A host control write can clear the status flags, rewind the pointer, or do both at once. A separate send pulse marks the moment a request leaves on the link. It starts a response timer, which sets a timeout flag if no message completes in time.

Top module: `link_msg_rx`

## Requirements
- R1: Bits [9:8] of `rx_word` select the word kind: 2'b10 opens a message (its byte is the target address), 2'b00 carries a data byte, 2'b01 closes a message (its byte is the CRC). A data or closing word that arrives while no message is open is ignored, and the pointer does not move.
- R2: Data bytes are stored two per 16-bit word, with the earlier byte in bits [15:8]. A message's first data byte lands at byte address start+2, where start is the pointer value when the message opened. The pointer is always even.
- R3: When a message closes, the word at byte address start holds the count of data bytes plus two. The count covers the address, header and payload bytes, and excludes the CRC.
- R4: The CRC is CRC-8 with polynomial 0x07, initial value 0x00, shifted MSB first over every data byte of the message. A mismatch sets `st_crc_err`. Every closed message sets `st_rcvd`. The CRC byte is not stored and does not advance the pointer.
- R5: When a message closes, the pointer advances by the data byte count plus two. The next message is appended there, and the pointer never decreases except by rewind.
- R6: `st_full` is set once the pointer reaches 0x17FE (the last word of a 3072-word buffer). It stays set until a clear. The pointer never exceeds 0x1800, and bytes beyond the buffer are dropped.
- R7: `send_cmd` sets `st_sent` and starts a timer of TO_CYC cycles. If no message closes before the timer expires, `st_timeout` is set.
- R8: A control write with `ctl_clr` high zeroes `st_sent`, `st_rcvd`, `st_crc_err`, `st_timeout` and `st_full` at the next edge, and stops the timer.
- R9: A control write with `ctl_rewind` high sets the pointer to 0 and drops any message in progress.
- R10: `ptr_rd` shows the byte pointer with its bytes swapped: bits [15:8] hold pointer bits [7:0].
- R11: An opening word that arrives inside an open message abandons that message and starts a new one at the same start address.
- R12: After reset, the pointer and all five status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | `rx_word` is valid this cycle |
| rx_word | input | 10 | Flag bits [9:8] and data byte [7:0] |
| send_cmd | input | 1 | Request sent; starts the response timer |
| ctl_wr | input | 1 | Host control write strobe |
| ctl_clr | input | 1 | With `ctl_wr`: clear the status bits |
| ctl_rewind | input | 1 | With `ctl_wr`: reset the pointer |
| rd_addr | input | AW | Buffer word address for the host read |
| rd_data | output | 16 | Buffer word, one cycle after `rd_addr` |
| ptr_rd | output | 16 | Byte pointer, byte-swapped |
| st_sent | output | 1 | Send issued |
| st_rcvd | output | 1 | Message received |
| st_crc_err | output | 1 | CRC mismatch seen |
| st_timeout | output | 1 | Response timer expired |
| st_full | output | 1 | Buffer full |

## Verification
The assertions assume that `rst` is held for at least one edge and that the host never rewinds while the pointer is expected to grow. A rewind is the only event allowed to lower the pointer. The stimulus issues control writes only between messages, and only on purpose. It sends only messages with an even data-byte count, since a message with an odd count is outside the protocol. The single exception is the deliberately truncated message used to check the abandon path. The assertions about status bits also rely on a clear always taking precedence over a set in the same cycle. The bench never drives a message close in the same cycle as a clear.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'b00,
    KIND_CLOSE = 2'b01,
    KIND_OPEN  = 2'b10,
    KIND_BAD   = 2'b11
  } word_kind_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/link_crc8.sv
module link_crc8
  import link_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       first,
  input  logic       more,
  input  logic [7:0] din,
  output logic [7:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst)        crc_q <= 8'h00;
    else if (first) crc_q <= crc8_step(8'h00, din);
    else if (more)  crc_q <= crc8_step(crc_q, din);
  end
endmodule

// File: rtl/link_buf.sv
module link_buf #(
  parameter int DEPTH = 3072,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/link_resp_timer.sv
module link_resp_timer #(
  parameter int LIMIT = 25488,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stop,
  output logic expire
);
  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (stop) begin
        armed <= 1'b0;
      end else if (arm) begin
        armed <= 1'b1;
        cnt   <= CW'(LIMIT);
      end else if (armed) begin
        if (cnt <= CW'(1)) begin
          armed  <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/link_msg_rx.sv
module link_msg_rx
  import link_rx_pkg::*;
#(
  parameter int DEPTH  = 3072,
  parameter int TO_CYC = 25488,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [9:0]    rx_word,
  input  logic          send_cmd,
  input  logic          ctl_wr,
  input  logic          ctl_clr,
  input  logic          ctl_rewind,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic [15:0]   ptr_rd,
  output logic          st_sent,
  output logic          st_rcvd,
  output logic          st_crc_err,
  output logic          st_timeout,
  output logic          st_full
);
  localparam int BUF_BYTES = 2 * DEPTH;
  localparam logic [PTR_W-1:0] BUF_END   = PTR_W'(BUF_BYTES);
  localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(BUF_BYTES - 2);

  word_kind_e       kind;
  logic [7:0]       din;
  logic [PTR_W-1:0] ptr_b, start_b, live_b, cnt;
  logic             in_msg, have_hi;
  logic [7:0]       hi_byte, crc_q;
  logic             do_clr, do_rw, is_open, is_data, is_close;
  logic             pair_we, len_we, to_expire;
  logic             buf_we;
  logic [AW-1:0]    buf_waddr;
  logic [15:0]      buf_wdata;

  function automatic logic [PTR_W-1:0] step2(input logic [PTR_W-1:0] x);
    return ((x + PTR_W'(2)) > BUF_END) ? BUF_END : (x + PTR_W'(2));
  endfunction

  assign kind     = word_kind_e'(rx_word[9:8]);
  assign din      = rx_word[7:0];
  assign do_clr   = ctl_wr & ctl_clr;
  assign do_rw    = ctl_wr & ctl_rewind;
  assign is_open  = rx_valid && !do_rw && kind == KIND_OPEN;
  assign is_data  = rx_valid && !do_rw && in_msg && kind == KIND_DATA;
  assign is_close = rx_valid && !do_rw && in_msg && kind == KIND_CLOSE;
  assign pair_we  = is_data && have_hi && (live_b < BUF_END);
  assign len_we   = is_close && (start_b < BUF_END);

  always_comb begin
    buf_we    = pair_we | len_we;
    buf_waddr = pair_we ? live_b[AW:1] : start_b[AW:1];
    buf_wdata = pair_we ? {hi_byte, din} : (cnt + 16'd2);
  end

  link_buf #(.DEPTH(DEPTH), .DW(16), .AW(AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  link_crc8 u_crc (
    .clk(clk), .rst(rst), .first(is_open), .more(is_data),
    .din(din), .crc_q(crc_q)
  );

  link_resp_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk(clk), .rst(rst), .arm(send_cmd), .stop(do_clr | is_close),
    .expire(to_expire)
  );

  // Message assembly and pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_b   <= '0;
      start_b <= '0;
      live_b  <= '0;
      cnt     <= '0;
      in_msg  <= 1'b0;
      have_hi <= 1'b0;
      hi_byte <= '0;
    end else if (do_rw) begin
      ptr_b   <= '0;
      in_msg  <= 1'b0;
      have_hi <= 1'b0;
    end else if (is_open) begin
      in_msg  <= 1'b1;
      start_b <= ptr_b;
      live_b  <= step2(ptr_b);
      hi_byte <= din;
      have_hi <= 1'b1;
      cnt     <= PTR_W'(1);
    end else if (is_data) begin
      cnt <= cnt + PTR_W'(1);
      if (!have_hi) begin
        hi_byte <= din;
        have_hi <= 1'b1;
      end else begin
        have_hi <= 1'b0;
        live_b  <= step2(live_b);
      end
    end else if (is_close) begin
      in_msg  <= 1'b0;
      have_hi <= 1'b0;
      ptr_b   <= live_b;
    end
  end

  // Status bits, clear has precedence
  always_ff @(posedge clk) begin
    if (rst || do_clr) begin
      st_sent    <= 1'b0;
      st_rcvd    <= 1'b0;
      st_crc_err <= 1'b0;
      st_timeout <= 1'b0;
      st_full    <= 1'b0;
    end else begin
      if (send_cmd)                  st_sent    <= 1'b1;
      if (is_close)                  st_rcvd    <= 1'b1;
      if (is_close && din != crc_q)  st_crc_err <= 1'b1;
      if (to_expire)                 st_timeout <= 1'b1;
      if (ptr_b >= FULL_MARK)        st_full    <= 1'b1;
    end
  end

  assign ptr_rd = {ptr_b[7:0], ptr_b[15:8]};
endmodule

// File: rtl/link_msg_rx_chk.sv
module link_msg_rx_chk #(
  parameter int BUF_BYTES = 6144
) (
  input logic        clk,
  input logic        rst,
  input logic        ctl_wr,
  input logic        ctl_clr,
  input logic        ctl_rewind,
  input logic [15:0] ptr_b,
  input logic        st_sent,
  input logic        st_rcvd,
  input logic        st_crc_err,
  input logic        st_timeout,
  input logic        st_full
);
  AST_PTR_EVEN: assert property (@(posedge clk) disable iff (rst)
    ptr_b[0] == 1'b0);                                                   // R2
  AST_PTR_GROWS: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_rewind) |=> ptr_b >= $past(ptr_b));                  // R5
  AST_PTR_CAP: assert property (@(posedge clk) disable iff (rst)
    ptr_b <= 16'(BUF_BYTES));                                            // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    st_full && !(ctl_wr && ctl_clr) |=> st_full);                        // R6
  AST_CLR_STATUS: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && ctl_clr |=> !(st_sent || st_rcvd || st_crc_err || st_timeout || st_full)); // R8
  AST_REWIND: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && ctl_rewind |=> ptr_b == 16'd0);                            // R9
  AST_TO_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
    $rose(st_timeout) |-> st_sent);                                      // R7
endmodule

bind link_msg_rx link_msg_rx_chk #(.BUF_BYTES(2 * DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_clr(ctl_clr),
  .ctl_rewind(ctl_rewind), .ptr_b(ptr_b), .st_sent(st_sent),
  .st_rcvd(st_rcvd), .st_crc_err(st_crc_err), .st_timeout(st_timeout),
  .st_full(st_full)
);

// File: tb/link_msg_rx_tb.sv
module link_msg_rx_tb;
  localparam int DEPTH  = 3072;
  localparam int TO_CYC = 300;
  localparam int AW     = $clog2(DEPTH);
  localparam int BUFB   = 2 * DEPTH;

  logic          clk = 1'b0;
  logic          rst;
  logic          rx_valid, send_cmd, ctl_wr, ctl_clr, ctl_rewind;
  logic [9:0]    rx_word;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data, ptr_rd;
  logic          st_sent, st_rcvd, st_crc_err, st_timeout, st_full;

  int errors = 0;
  int checks = 0;
  int ptr_m  = 0;
  logic [7:0] mb [6200];

  always #5 clk = ~clk;

  link_msg_rx #(.DEPTH(DEPTH), .TO_CYC(TO_CYC)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .send_cmd(send_cmd), .ctl_wr(ctl_wr), .ctl_clr(ctl_clr),
    .ctl_rewind(ctl_rewind), .rd_addr(rd_addr), .rd_data(rd_data),
    .ptr_rd(ptr_rd), .st_sent(st_sent), .st_rcvd(st_rcvd),
    .st_crc_err(st_crc_err), .st_timeout(st_timeout), .st_full(st_full)
  );

  function automatic logic [7:0] crc_ref(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c = c ^ mb[i];
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] swap_ref(input int p);
    logic [15:0] v = 16'(p);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] b);
    rx_valid = 1'b1;
    rx_word  = {k, b};
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic ctl(input bit c, input bit r);
    ctl_wr = 1'b1; ctl_clr = c; ctl_rewind = r;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_clr = 1'b0; ctl_rewind = 1'b0;
  endtask

  task automatic rd(input int waddr, output logic [15:0] v);
    rd_addr = AW'(waddr);
    @(negedge clk);
    v = rd_data;
  endtask

  // Sends one message of n data bytes (n even), returns its start address.
  task automatic send_msg(input int n, input bit bad, output int start);
    logic [7:0] c;
    for (int i = 0; i < n; i++) mb[i] = 8'($urandom);
    c = crc_ref(n) ^ (bad ? 8'h5A : 8'h00);
    start = ptr_m;
    put(2'b10, mb[0]);
    for (int i = 1; i < n; i++) put(2'b00, mb[i]);
    put(2'b01, c);
    ptr_m = (ptr_m + 2 + n > BUFB) ? BUFB : ptr_m + 2 + n;
    @(negedge clk);
  endtask

  task automatic verify(input int start, input int n, input bit bad);
    logic [15:0] v;
    int k;
    if (start < BUFB) begin
      rd(start / 2, v);
      chk(v == 16'(n + 2), "R3 length word", v, n + 2);
    end
    if (start + 2 < BUFB) begin
      rd(start / 2 + 1, v);
      chk(v == {mb[0], mb[1]}, "R2 first pair", v, {mb[0], mb[1]});
    end
    k = $urandom % (n / 2);
    if (start + 2 + 2 * k < BUFB) begin
      rd(start / 2 + 1 + k, v);
      chk(v == {mb[2*k], mb[2*k+1]}, "R2 random pair", v, {mb[2*k], mb[2*k+1]});
    end
    chk(ptr_rd == swap_ref(ptr_m), "R5/R10 pointer", ptr_rd, swap_ref(ptr_m));
    chk(st_crc_err == bad, "R4 crc flag", st_crc_err, bad);
    chk(st_rcvd == 1'b1, "R4 received flag", st_rcvd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int st, n;
    bit bad;
    logic [15:0] v;
    void'($urandom(32'd4711));
    rx_valid = 0; rx_word = '0; send_cmd = 0; ctl_wr = 0; ctl_clr = 0;
    ctl_rewind = 0; rd_addr = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(ptr_rd == 16'h0 && {st_sent, st_rcvd, st_crc_err, st_timeout, st_full} == 5'b0,
        "R12 reset", {ptr_rd, 3'b0, st_sent, st_rcvd, st_crc_err, st_timeout, st_full}, 0);

    // R1 stray words outside a message
    put(2'b00, 8'h33); put(2'b01, 8'h44); @(negedge clk);
    chk(ptr_rd == 16'h0 && !st_rcvd, "R1 stray ignored", ptr_rd, 0);

    // R7 send with prompt response: no timeout
    send_cmd = 1'b1; @(negedge clk); send_cmd = 1'b0;
    chk(st_sent == 1'b1, "R7 sent flag", st_sent, 1);
    send_msg(14, 1'b0, st);
    verify(st, 14, 1'b0);
    repeat (TO_CYC + 20) @(negedge clk);
    chk(st_timeout == 1'b0, "R7 no timeout after response", st_timeout, 0);

    // R4 R5 random messages, some with bad CRC, appended back to back
    for (int m = 0; m < 8; m++) begin
      ctl(1'b1, 1'b0);
      chk(!(st_rcvd || st_crc_err || st_sent), "R8 clear", {st_rcvd, st_crc_err, st_sent}, 0);
      n   = 10 + 2 * ($urandom % 12);
      bad = ($urandom % 3) == 0;
      send_msg(n, bad, st);
      verify(st, n, bad);
    end

    // R11 open word mid-message restarts at same start
    ctl(1'b1, 1'b0);
    put(2'b10, 8'hA1); put(2'b00, 8'hB2); put(2'b00, 8'hC3);
    send_msg(12, 1'b0, st);
    verify(st, 12, 1'b0);

    // R9 rewind
    ctl(1'b0, 1'b1);
    ptr_m = 0;
    chk(ptr_rd == 16'h0, "R9 rewind", ptr_rd, 0);
    ctl(1'b1, 1'b0);
    send_msg(10, 1'b0, st);
    chk(st == 0, "R9 message at zero", st, 0);
    verify(st, 10, 1'b0);

    // R7 timeout without response
    ctl(1'b1, 1'b0);
    send_cmd = 1'b1; @(negedge clk); send_cmd = 1'b0;
    repeat (TO_CYC + 10) @(negedge clk);
    chk(st_timeout == 1'b1, "R7 timeout", st_timeout, 1);
    ctl(1'b1, 1'b0);
    chk(st_timeout == 1'b0, "R8 timeout cleared", st_timeout, 0);

    // R6 fill the buffer
    ctl(1'b1, 1'b1);
    ptr_m = 0;
    send_msg(6140, 1'b0, st);
    verify(st, 6140, 1'b0);
    chk(st_full == 1'b1, "R6 full at 0x17FE", st_full, 1);
    ctl(1'b1, 1'b0);
    chk(st_full == 1'b0, "R8 full cleared", st_full, 0);
    @(negedge clk);
    chk(st_full == 1'b1, "R6 full re-flags", st_full, 1);
    send_msg(10, 1'b0, st);
    chk(ptr_rd == swap_ref(BUFB), "R6 pointer capped", ptr_rd, swap_ref(BUFB));
    rd(DEPTH - 1, v);
    chk(v == 16'd12, "R6 length in last word", v, 12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule